// File: doc/BRIEF.md
# Multi-Source Reset Supervisor

This block merges the reset requests of a small microcontroller core into a single internal reset. Five requests feed it: a power-on comparator flag, an active-low external reset pin, a watchdog expiry pulse, a low-supply (brown-out) comparator flag and a reset bit held in the JTAG scan logic. The watchdog and brown-out requests only count while their enable inputs are set. The external pin is synchronized and must stay low for a minimum number of clock cycles before it is accepted, so short glitches on the board trace are rejected.

Any accepted request drives the I/O-port reset output and the internal core reset high at once, through an asynchronous path that needs no running clock. Once every request has gone away, the core reset is stretched by a count of clock cycles picked by a 2-bit delay code. It then falls on a clock edge, so the core sees a clean, synchronous release. If a request comes back while the stretch is running, the count is thrown away. A fresh, full stretch starts only when all requests are quiet again.

Top module: `rstsup_top`

## Requirements
- R1: Each of the five requests on its own asserts `coreReset` and `portReset`: `pwrOnFlag`=1, an accepted low on `extRstN`, `wdtExpire`=1 with `wdtEnable`=1, `lowSupply`=1 with `brownEnable`=1, and `jtagRstBit`=1.
- R2: `portReset` goes high combinationally as soon as any accepted request is active, even with the clock stopped. It stays high for as long as `coreReset` is high.
- R3: `coreReset` is set asynchronously, without a clock edge, when any accepted request becomes active. It stays high while any request is active.
- R4: After the last request goes inactive, `coreReset` falls on the Nth rising clock edge, where N = 16 << (4*`delaySel`). This gives 16, 256, 4096 or 65536 cycles for codes 0, 1, 2 and 3. `delaySel` must be held stable during a stretch.
- R5: `extRstN` passes through a two-flop synchronizer. A low level held across at least MIN_LOW consecutive rising edges is accepted (MIN_LOW defaults to 4). A shorter low pulse leaves `coreReset` and `portReset` at 0.
- R6: A `wdtExpire` pulse has no effect while `wdtEnable`=0. While `wdtEnable`=1, a one-cycle pulse triggers a full reset.
- R7: `lowSupply` has no effect while `brownEnable`=0. While `brownEnable`=1, it triggers a reset.
- R8: A JTAG reset stays in force for as long as `jtagRstBit` is 1, however long that is.
- R9: A request that becomes active during the stretch cancels the count. This holds even when it arrives just before the release edge. The full stretch then restarts after that request ends.
- R10: An accepted external reset ends on the third rising edge after `extRstN` returns high. The stretch of R4 counts from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| pwrOnFlag | input | 1 | Power-on comparator flag, high while supply is below threshold |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| wdtExpire | input | 1 | Watchdog expiry pulse |
| wdtEnable | input | 1 | Watchdog enable |
| lowSupply | input | 1 | Brown-out comparator flag, high on low supply |
| brownEnable | input | 1 | Brown-out detector enable |
| jtagRstBit | input | 1 | JTAG reset-register bit, active high |
| delaySel | input | 2 | Stretch length code |
| coreReset | output | 1 | Internal reset, asynchronous set, synchronous release |
| portReset | output | 1 | Immediate I/O-port reset |

## Verification
Two of the block's functions can fall in the same cycle: the stretch counter reaching its release edge, and a new request restarting it. The bench provokes this by letting the count run to one edge short of release. It then raises the JTAG bit in the half-cycle just before the releasing edge. The check passes only if `coreReset` stays high across that edge and a complete new stretch follows the request's end. The external filter is swept over every low-pulse length from one edge up to beyond the threshold. Each length is judged against the arithmetic acceptance rule and the expected release edge.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  // Number of reset request inputs merged by the block.
  localparam int NUM_SRC = 5;

  // Bit positions inside the request vector (priority does not matter).
  localparam int SRC_PWR  = 0;
  localparam int SRC_EXT  = 1;
  localparam int SRC_WDT  = 2;
  localparam int SRC_BRN  = 3;
  localparam int SRC_JTAG = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic cntAdvance;  // step the stretch counter
    logic cntZero;     // hold the stretch counter at zero
  } dpStrobes_t;

endpackage

// File: rtl/rstsup_dp.sv
module rstsup_dp
  import rstsup_pkg::*;
#(
  parameter int MIN_LOW  = 4,
  parameter int BASE_LOG = 4,
  parameter int STEP_LOG = 4,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             pwrOnFlag,
  input  logic             extRstN,
  input  logic [SEL_W-1:0] delaySel,
  input  logic             srcActive,
  input  logic             coreReset,
  input  dpStrobes_t       stb,
  output logic             extQual,
  output logic             stretchDone
);

  localparam int NUM_CODES = 1 << SEL_W;
  localparam int CW        = BASE_LOG + (NUM_CODES - 1) * STEP_LOG + 1;
  localparam int LW        = $clog2(MIN_LOW + 1);

  logic [1:0]    syncQ;
  logic [LW-1:0] lowCnt;
  logic [CW-1:0] delayCnt;
  logic [CW-1:0] limTab [NUM_CODES];
  logic [CW-1:0] stretchLimit;

  // Two-flop synchronizer for the external pin; idles high.
  always_ff @(posedge clk or posedge pwrOnFlag) begin
    if (pwrOnFlag) syncQ <= 2'b11;
    else           syncQ <= {syncQ[0], extRstN};
  end

  // Saturating low-level counter: qualifies a long enough low.
  always_ff @(posedge clk or posedge pwrOnFlag) begin
    if (pwrOnFlag)                   lowCnt <= '0;
    else if (syncQ[1])               lowCnt <= '0;
    else if (lowCnt != LW'(MIN_LOW)) lowCnt <= lowCnt + LW'(1);
  end

  assign extQual = (lowCnt == LW'(MIN_LOW));

  // Stretch lengths, one per code, each a power of two.
  generate
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
      assign limTab[g] = CW'(1) << (BASE_LOG + g * STEP_LOG);
    end
  endgenerate

  assign stretchLimit = limTab[delaySel];

  // Stretch counter: cleared asynchronously by any active request.
  always_ff @(posedge clk or posedge srcActive) begin
    if (srcActive)          delayCnt <= '0;
    else if (stb.cntZero)   delayCnt <= '0;
    else if (stb.cntAdvance) delayCnt <= delayCnt + CW'(1);
  end

  assign stretchDone = (delayCnt == stretchLimit - CW'(1));

  // R5: qualification only follows MIN_LOW synchronized low samples.
  p_ext_filter_r5: assert property (@(posedge clk) disable iff (pwrOnFlag)
    $rose(extQual) |-> ($past(lowCnt) == LW'(MIN_LOW - 1)) && !$past(syncQ[1]))
    else $error("R5 external reset qualified too early");

  // R4: the core reset falls only when the count reached its limit.
  p_release_count_r4: assert property (@(posedge clk) disable iff (pwrOnFlag)
    $fell(coreReset) |-> ($past(delayCnt) == $past(stretchLimit) - CW'(1)))
    else $error("R4 release at wrong count");

  // R4: the counter rests at zero outside of a stretch.
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (pwrOnFlag)
    !coreReset |-> (delayCnt == '0))
    else $error("R4 counter not idle");

endmodule

// File: rtl/rstsup_ctl.sv
module rstsup_ctl
  import rstsup_pkg::*;
(
  input  logic       clk,
  input  logic       pwrOnFlag,
  input  logic       wdtExpire,
  input  logic       wdtEnable,
  input  logic       lowSupply,
  input  logic       brownEnable,
  input  logic       jtagRstBit,
  input  logic       extQual,
  input  logic       stretchDone,
  output logic       srcActive,
  output logic       coreReset,
  output logic       portReset,
  output dpStrobes_t stb
);

  logic [NUM_SRC-1:0] reqVec;
  logic               holdQ;

  // Gate the enable-controlled requests and merge all of them.
  always_comb begin
    reqVec           = '0;
    reqVec[SRC_PWR]  = pwrOnFlag;
    reqVec[SRC_EXT]  = extQual;
    reqVec[SRC_WDT]  = wdtExpire & wdtEnable;
    reqVec[SRC_BRN]  = lowSupply & brownEnable;
    reqVec[SRC_JTAG] = jtagRstBit;
  end

  assign srcActive = |reqVec;

  // Asynchronous set, synchronous release after the stretch.
  always_ff @(posedge clk or posedge srcActive) begin
    if (srcActive)                         holdQ <= 1'b1;
    else if (stb.cntAdvance && stretchDone) holdQ <= 1'b0;
  end

  always_comb begin
    stb.cntAdvance = holdQ;
    stb.cntZero    = ~holdQ | stretchDone;
  end

  assign coreReset = holdQ;
  assign portReset = srcActive | holdQ;

  // R3: core reset is high whenever a request is active.
  p_hold_active_r3: assert property (@(posedge clk) disable iff (pwrOnFlag)
    srcActive |-> coreReset)
    else $error("R3 core reset low during active request");

  // R8: the JTAG bit keeps both resets asserted.
  p_jtag_hold_r8: assert property (@(posedge clk) disable iff (pwrOnFlag)
    jtagRstBit |-> (coreReset && portReset))
    else $error("R8 JTAG reset not held");

  // R9: a release edge never follows a cycle with an active request.
  p_no_release_active_r9: assert property (@(posedge clk) disable iff (pwrOnFlag)
    $fell(coreReset) |-> !$past(srcActive))
    else $error("R9 released while a request was active");

endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
  import rstsup_pkg::*;
#(
  parameter int MIN_LOW  = 4,
  parameter int BASE_LOG = 4,
  parameter int STEP_LOG = 4,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             pwrOnFlag,
  input  logic             extRstN,
  input  logic             wdtExpire,
  input  logic             wdtEnable,
  input  logic             lowSupply,
  input  logic             brownEnable,
  input  logic             jtagRstBit,
  input  logic [SEL_W-1:0] delaySel,
  output logic             coreReset,
  output logic             portReset
);

  logic       srcActive;
  logic       extQual;
  logic       stretchDone;
  dpStrobes_t stb;

  rstsup_ctl i_ctl (
    .clk         (clk),
    .pwrOnFlag   (pwrOnFlag),
    .wdtExpire   (wdtExpire),
    .wdtEnable   (wdtEnable),
    .lowSupply   (lowSupply),
    .brownEnable (brownEnable),
    .jtagRstBit  (jtagRstBit),
    .extQual     (extQual),
    .stretchDone (stretchDone),
    .srcActive   (srcActive),
    .coreReset   (coreReset),
    .portReset   (portReset),
    .stb         (stb)
  );

  rstsup_dp #(
    .MIN_LOW  (MIN_LOW),
    .BASE_LOG (BASE_LOG),
    .STEP_LOG (STEP_LOG),
    .SEL_W    (SEL_W)
  ) i_dp (
    .clk         (clk),
    .pwrOnFlag   (pwrOnFlag),
    .extRstN     (extRstN),
    .delaySel    (delaySel),
    .srcActive   (srcActive),
    .coreReset   (coreReset),
    .stb         (stb),
    .extQual     (extQual),
    .stretchDone (stretchDone)
  );

endmodule

// File: tb/test_rstsup_top.sv
module test_rstsup_top;

  localparam int MIN_LOW = 4;

  logic       clk = 1'b0;
  logic       clkRun = 1'b1;
  logic       pwrOnFlag;
  logic       extRstN = 1'b1;
  logic       wdtExpire = 1'b0;
  logic       wdtEnable = 1'b0;
  logic       lowSupply = 1'b0;
  logic       brownEnable = 1'b0;
  logic       jtagRstBit = 1'b0;
  logic [1:0] delaySel = 2'd0;
  logic       coreReset;
  logic       portReset;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  rstsup_top #(.MIN_LOW(MIN_LOW)) i_rstsup_top (
    .clk(clk), .pwrOnFlag(pwrOnFlag), .extRstN(extRstN),
    .wdtExpire(wdtExpire), .wdtEnable(wdtEnable),
    .lowSupply(lowSupply), .brownEnable(brownEnable),
    .jtagRstBit(jtagRstBit), .delaySel(delaySel),
    .coreReset(coreReset), .portReset(portReset)
  );

  // 125 MHz: 8 ns period, gated for the clock-stopped test.
  always begin
    #4;
    if (clkRun) clk = ~clk;
  end

  function automatic int stretchLen(input int sel);
    return 16 << (4 * sel);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expect release exactly on the Nth edge after the current negedge.
  task automatic expectRelease(input string req, input int n);
    tick(n - 1);
    chk({req, " held before release"}, coreReset, 1'b1);
    tick(1);
    chk({req, " released on time"}, coreReset, 1'b0);
    chk({req, " port reset released"}, portReset, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    pwrOnFlag = 1'b1;
    #1;
    // R1 / R3: power-on flag asserts both outputs without an edge
    chk("R1 power-on core", coreReset, 1'b1);
    chk("R2 power-on port", portReset, 1'b1);
    tick(3);
    pwrOnFlag = 1'b0;
    expectRelease("R4 power-on sel0", stretchLen(0));

    // R4: sweep every delay code through a JTAG request
    for (int sel = 0; sel < 4; sel++) begin
      delaySel = sel[1:0];
      jtagRstBit = 1'b1;
      #1 chk("R8 jtag asserts", coreReset, 1'b1);
      tick(5);
      chk("R8 jtag held", coreReset, 1'b1);
      jtagRstBit = 1'b0;
      #1 chk("R2 port tracks stretch", portReset, 1'b1);
      expectRelease("R4 stretch sweep", stretchLen(sel));
    end
    delaySel = 2'd0;

    // R5 / R10: sweep external low pulse lengths
    for (int n = 1; n <= MIN_LOW + 3; n++) begin
      bit sawHigh = 0;
      extRstN = 1'b0;
      for (int k = 0; k < n; k++) begin
        tick(1);
        if (coreReset || portReset) sawHigh = 1;
      end
      extRstN = 1'b1;
      if (n >= MIN_LOW) begin
        tick(2);
        chk("R5 long low accepted", coreReset, 1'b1);
        chk("R1 ext port reset", portReset, 1'b1);
        expectRelease("R10 ext release", stretchLen(0) + 1);
      end else begin
        for (int k = 0; k < 6; k++) begin
          tick(1);
          if (coreReset || portReset) sawHigh = 1;
        end
        chk("R5 short low ignored", sawHigh, 1'b0);
      end
    end

    // R6: watchdog gated, then enabled
    wdtExpire = 1'b1;
    #1 chk("R6 wdt disabled port", portReset, 1'b0);
    tick(1);
    wdtExpire = 1'b0;
    tick(3);
    chk("R6 wdt disabled core", coreReset, 1'b0);
    wdtEnable = 1'b1;
    wdtExpire = 1'b1;
    #1 chk("R6 wdt enabled", coreReset, 1'b1);
    tick(1);
    wdtExpire = 1'b0;
    expectRelease("R6 wdt stretch", stretchLen(0));
    wdtEnable = 1'b0;

    // R7: brown-out gated, then enabled
    lowSupply = 1'b1;
    tick(4);
    chk("R7 brown-out disabled", coreReset | portReset, 1'b0);
    brownEnable = 1'b1;
    #1 chk("R7 brown-out enabled", coreReset, 1'b1);
    tick(4);
    lowSupply = 1'b0;
    expectRelease("R7 brown-out stretch", stretchLen(0));
    brownEnable = 1'b0;

    // R9: retrigger mid-stretch restarts a full count
    jtagRstBit = 1'b1;
    tick(2);
    jtagRstBit = 1'b0;
    tick(10);
    jtagRstBit = 1'b1;
    tick(2);
    jtagRstBit = 1'b0;
    tick(15);
    chk("R9 restart extends", coreReset, 1'b1);
    tick(1);
    chk("R9 restart release", coreReset, 1'b0);

    // R9: request arrives in the half-cycle before the release edge
    jtagRstBit = 1'b1;
    tick(1);
    jtagRstBit = 1'b0;
    tick(stretchLen(0) - 1);
    jtagRstBit = 1'b1;
    tick(1);
    chk("R9 collision held", coreReset, 1'b1);
    jtagRstBit = 1'b0;
    expectRelease("R9 collision restart", stretchLen(0));

    // R2: assertion with the clock stopped
    clkRun = 1'b0;
    #20;
    jtagRstBit = 1'b1;
    #1;
    chk("R2 no-clock port", portReset, 1'b1);
    chk("R3 no-clock core", coreReset, 1'b1);
    #20;
    jtagRstBit = 1'b0;
    #20;
    chk("R3 no-clock hold", coreReset, 1'b1);
    chk("R2 no-clock port hold", portReset, 1'b1);
    clkRun = 1'b1;
    expectRelease("R4 after clock restart", stretchLen(0));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule